// File: doc/BRIEF.md
# Vector Lane Extract-to-Register Unit

This unit takes one 32-bit instruction word that asks for a single lane of a 64-bit vector register to be moved into a 32-bit general register. It decodes and executes that word. The unit validates the fixed opcode bits and decodes the lane width (byte, halfword or word) and the lane index from one merged field. While the request is presented, it drives the source register number onto a read port and picks the lane out of the returned 64-bit value. It then zero- or sign-extends the lane to 32 bits.

The result comes out one cycle after a request is accepted and is held in a registered valid/ready stage. The result carries a write enable, a destination index, the data, and three fault flags: undefined, unpredictable and trap. Two inputs gate execution. One reports that the condition check passed. The other enables the floating-point and vector unit. A third input reports that the vector extension is present, because the byte and halfword forms need it and the word form does not. The latency is the same for every data value, every condition outcome and every fault.

Top module: `lane_extract_unit`

## Requirements
- R1: After reset `rspValid` is 0 and `reqReady` is 1. `reqReady` equals `!rspValid || rspReady`. A request accepted on a rising edge (`reqValid && reqReady`) appears on the response outputs after that edge. A response is held unchanged while `rspReady` is low.
- R2: The merge field is {bit23 = U, bits22:21 = opc1, bits6:5 = opc2}. When opc1[1] = 1, the lane is 8 bits wide and its index is {bit21, bit6, bit5}, so lane k is bits 8k+7:8k of the source register.
- R3: When opc1[1] = 0 and opc2[0] = 1, the lane is 16 bits wide and its index is {bit21, bit6}.
- R4: When U = 0, opc1[1] = 0 and opc2 = 00, the lane is 32 bits wide and its index is bit21. This form executes even when `vecPresent` is 0.
- R5: For byte and halfword lanes, U = 1 zero-extends the lane to 32 bits and U = 0 sign-extends it.
- R6: The word is undefined in any of these cases: the field matches 10x00 or x0x10; bits27:24 differ from 1110; bit20 differs from 1; bits11:8 differ from 1011; bit4 differs from 1; bits31:28 equal 1111 when `compactForm` = 0; bits31:28 differ from 1110 when `compactForm` = 1. An undefined word sets the undefined flag, clears the unpredictable and trap flags, and does not write. This holds whatever the gating inputs are.
- R7: While `reqValid` is high, `rfRdAddr` equals {bit7, bits19:16}. The response destination `rspDest` equals bits15:12.
- R8: With `condPass` = 0, a defined word retires with no write and no trap.
- R9: With `condPass` = 1, the trap flag is set and no write happens in either of these cases: `unitEnable` is 0, or the lane is 8 or 16 bits wide while `vecPresent` is 0.
- R10: Destination 15 sets the unpredictable flag and suppresses the write. Destination 13 writes normally.
- R11: Nonzero bits3:0 set the unpredictable flag, but the instruction still executes and writes.
- R12: `rspData` is zero whenever `rspWrEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request presented |
| reqReady | output | 1 | Unit can accept a request |
| instrWord | input | 32 | Instruction word to decode |
| compactForm | input | 1 | 1: bits31:28 must be 1110; 0: bits31:28 are a condition field other than 1111 |
| condPass | input | 1 | Condition check passed |
| unitEnable | input | 1 | Floating-point/vector unit enabled |
| vecPresent | input | 1 | Vector extension present |
| rfRdAddr | output | 5 | Vector register read address |
| rfRdData | input | 64 | Vector register read data, same cycle |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Consumer takes the response |
| rspWrEn | output | 1 | General register write enable |
| rspDest | output | 4 | General register index |
| rspData | output | 32 | Extended lane value |
| rspUndef | output | 1 | Undefined encoding |
| rspUnpred | output | 1 | Unpredictable encoding |
| rspTrap | output | 1 | Execution trapped |

## Verification
The bench sweeps every byte and halfword index with both extension modes, using register contents whose lane top bits vary. A wrong index mapping or a swapped extension sense would therefore return the wrong lane or the wrong upper bits. It targets the overlap points of the merged field, 10x00 and x0x10, where a decoder that tests the patterns in the wrong priority would execute an undefined word as a word or halfword move. It also covers a word move with the vector extension absent, where a design that traps on it would lose a legal transfer. It covers destinations 13 and 15, nonzero low bits, gating with a failed condition, and back-to-back requests against a stalled consumer, where a faulty handshake would drop or overwrite a held response.

// File: rtl/lx_pkg.sv
package lx_pkg;
  localparam int LANE_IDX_W = 3;
  localparam int GREG_IDX_W = 4;
  localparam int VREG_IDX_W = 5;

  typedef enum logic [1:0] {
    LANE_BYTE = 2'd0,
    LANE_HALF = 2'd1,
    LANE_WORD = 2'd2
  } laneSizeE;

  typedef struct packed {
    laneSizeE                laneSize;
    logic [LANE_IDX_W-1:0]   laneIdx;
    logic                    zeroExt;
    logic                    needsVec;
    logic                    undef;
    logic                    unpred;
    logic [GREG_IDX_W-1:0]   dest;
    logic [VREG_IDX_W-1:0]   src;
  } decodeT;

  typedef struct packed {
    logic                    load;
    laneSizeE                laneSize;
    logic [LANE_IDX_W-1:0]   laneIdx;
    logic                    zeroExt;
    logic                    wrEn;
    logic [GREG_IDX_W-1:0]   dest;
    logic                    undef;
    logic                    unpred;
    logic                    trap;
  } ctrlStrobesT;
endpackage

// File: rtl/lx_decode.sv
module lx_decode
  import lx_pkg::*;
(
  input  logic [31:0] instrWord,
  input  logic        compactForm,
  output decodeT      dec
);
  logic [4:0] mergeFld;
  logic       condFieldOk;
  logic       fixedOk;
  logic       patUndef;

  // merged field: {U, opc1[1], opc1[0], opc2[1], opc2[0]}
  assign mergeFld    = {instrWord[23], instrWord[22:21], instrWord[6:5]};
  assign condFieldOk = compactForm ? (instrWord[31:28] == 4'b1110)
                                   : (instrWord[31:28] != 4'b1111);
  assign fixedOk     = condFieldOk
                    && (instrWord[27:24] == 4'b1110)
                    && instrWord[20]
                    && (instrWord[11:8] == 4'b1011)
                    && instrWord[4];

  always_comb begin
    dec          = '0;
    dec.laneSize = LANE_WORD;
    patUndef     = 1'b0;
    casez (mergeFld)
      5'b?1???: begin
        dec.laneSize = LANE_BYTE;
        dec.laneIdx  = mergeFld[2:0];
      end
      5'b?0??1: begin
        dec.laneSize = LANE_HALF;
        dec.laneIdx  = {1'b0, mergeFld[2:1]};
      end
      5'b00?00: begin
        dec.laneSize = LANE_WORD;
        dec.laneIdx  = {2'b00, mergeFld[2]};
      end
      default: patUndef = 1'b1;
    endcase
    dec.zeroExt  = mergeFld[4];
    dec.needsVec = (dec.laneSize != LANE_WORD);
    dec.undef    = !fixedOk || patUndef;
    dec.unpred   = !dec.undef
                && ((instrWord[15:12] == 4'hF) || (instrWord[3:0] != 4'h0));
    dec.dest     = instrWord[15:12];
    dec.src      = {instrWord[7], instrWord[19:16]};
  end
endmodule

// File: rtl/lx_ctrl.sv
module lx_ctrl
  import lx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [31:0]           instrWord,
  input  logic                  compactForm,
  input  logic                  condPass,
  input  logic                  unitEnable,
  input  logic                  vecPresent,
  input  logic                  rspReady,
  output logic                  rspValid,
  output logic [VREG_IDX_W-1:0] rfRdAddr,
  output ctrlStrobesT           strb
);
  decodeT dec;
  logic   validQ;
  logic   accept;
  logic   trapNow;
  logic   writeNow;

  lx_decode decode_i (
    .instrWord   (instrWord),
    .compactForm (compactForm),
    .dec         (dec)
  );

  assign reqReady = !validQ || rspReady;
  assign accept   = reqValid && reqReady;
  assign rspValid = validQ;
  assign rfRdAddr = dec.src;

  // gating: traps only matter once the condition has passed
  assign trapNow  = !dec.undef && condPass
                 && (!unitEnable || (dec.needsVec && !vecPresent));
  assign writeNow = !dec.undef && condPass && !trapNow
                 && (dec.dest != 4'hF);

  always_comb begin
    strb.load     = accept;
    strb.laneSize = dec.laneSize;
    strb.laneIdx  = dec.laneIdx;
    strb.zeroExt  = dec.zeroExt;
    strb.wrEn     = writeNow;
    strb.dest     = dec.dest;
    strb.undef    = dec.undef;
    strb.unpred   = dec.unpred;
    strb.trap     = trapNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (accept) begin
      validQ <= 1'b1;
    end else if (rspReady) begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/lx_datapath.sv
module lx_datapath
  import lx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VREG_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobesT           strb,
  input  logic [VREG_W-1:0]     rfRdData,
  output logic                  rspWrEn,
  output logic [GREG_IDX_W-1:0] rspDest,
  output logic [DATA_W-1:0]     rspData,
  output logic                  rspUndef,
  output logic                  rspUnpred,
  output logic                  rspTrap
);
  localparam int NUM_SIZES = 3;

  logic [DATA_W-1:0] extVal [NUM_SIZES];
  logic [DATA_W-1:0] laneSel;

  // one extractor per lane width, all evaluated every cycle
  for (genvar g = 0; g < NUM_SIZES; g++) begin : gSize
    localparam int LW = 8 << g;
    localparam int LN = VREG_W / LW;
    localparam int IW = $clog2(LN);
    logic [LW-1:0] lanes [LN];
    logic [LW-1:0] picked;

    for (genvar l = 0; l < LN; l++) begin : gLane
      assign lanes[l] = rfRdData[l*LW +: LW];
    end

    assign picked = lanes[strb.laneIdx[IW-1:0]];

    if (LW < DATA_W) begin : gExt
      assign extVal[g] = strb.zeroExt ? {{(DATA_W-LW){1'b0}}, picked}
                                      : {{(DATA_W-LW){picked[LW-1]}}, picked};
    end else begin : gFull
      assign extVal[g] = picked[DATA_W-1:0];
    end
  end

  always_comb begin
    case (strb.laneSize)
      LANE_BYTE: laneSel = extVal[0];
      LANE_HALF: laneSel = extVal[1];
      default:   laneSel = extVal[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspWrEn   <= 1'b0;
      rspDest   <= '0;
      rspData   <= '0;
      rspUndef  <= 1'b0;
      rspUnpred <= 1'b0;
      rspTrap   <= 1'b0;
    end else if (strb.load) begin
      rspWrEn   <= strb.wrEn;
      rspDest   <= strb.dest;
      rspData   <= strb.wrEn ? laneSel : '0;
      rspUndef  <= strb.undef;
      rspUnpred <= strb.unpred;
      rspTrap   <= strb.trap;
    end
  end
endmodule

// File: rtl/lane_extract_unit.sv
module lane_extract_unit
  import lx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VREG_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [31:0]           instrWord,
  input  logic                  compactForm,
  input  logic                  condPass,
  input  logic                  unitEnable,
  input  logic                  vecPresent,
  output logic [VREG_IDX_W-1:0] rfRdAddr,
  input  logic [VREG_W-1:0]     rfRdData,
  output logic                  rspValid,
  input  logic                  rspReady,
  output logic                  rspWrEn,
  output logic [GREG_IDX_W-1:0] rspDest,
  output logic [DATA_W-1:0]     rspData,
  output logic                  rspUndef,
  output logic                  rspUnpred,
  output logic                  rspTrap
);
  ctrlStrobesT strb;

  lx_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .instrWord   (instrWord),
    .compactForm (compactForm),
    .condPass    (condPass),
    .unitEnable  (unitEnable),
    .vecPresent  (vecPresent),
    .rspReady    (rspReady),
    .rspValid    (rspValid),
    .rfRdAddr    (rfRdAddr),
    .strb        (strb)
  );

  lx_datapath #(
    .DATA_W (DATA_W),
    .VREG_W (VREG_W)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rfRdData  (rfRdData),
    .rspWrEn   (rspWrEn),
    .rspDest   (rspDest),
    .rspData   (rspData),
    .rspUndef  (rspUndef),
    .rspUnpred (rspUnpred),
    .rspTrap   (rspTrap)
  );
endmodule

// File: rtl/lx_checker.sv
module lx_checker #(
  parameter int DATA_W = 32,
  parameter int VREG_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [31:0]       instrWord,
  input logic              condPass,
  input logic [4:0]        rfRdAddr,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspWrEn,
  input logic [3:0]        rspDest,
  input logic [DATA_W-1:0] rspData,
  input logic              rspUndef,
  input logic              rspUnpred,
  input logic              rspTrap
);
  assert_rsp_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid);

  assert_hold_on_stall_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspData) && $stable(rspWrEn)
                              && $stable(rspDest) && $stable(rspUndef));

  assert_stall_blocks_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |-> !reqReady);

  assert_src_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> rfRdAddr == {instrWord[7], instrWord[19:16]});

  assert_undef_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspUndef |-> !rspWrEn && !rspUnpred && !rspTrap);

  assert_condfail_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !condPass |=> !rspWrEn && !rspTrap);

  assert_trap_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspTrap |-> !rspWrEn);

  assert_pc_dest_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspDest == 4'hF |-> !rspWrEn);

  assert_zero_data_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspWrEn |-> rspData == '0);
endmodule

bind lane_extract_unit lx_checker #(.DATA_W(DATA_W), .VREG_W(VREG_W)) chk_i (.*);

// File: tb/lane_extract_unit_tb_top.sv
`timescale 1ns/1ps
module lane_extract_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] instrWord = '0;
  logic        compactForm = 1'b0;
  logic        condPass = 1'b1;
  logic        unitEnable = 1'b1;
  logic        vecPresent = 1'b1;
  logic [4:0]  rfRdAddr;
  logic [63:0] rfRdData;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic        rspWrEn;
  logic [3:0]  rspDest;
  logic [31:0] rspData;
  logic        rspUndef, rspUnpred, rspTrap;

  always #2 clk = ~clk;

  logic [63:0] regs [32];
  assign rfRdData = regs[rfRdAddr];

  lane_extract_unit dut_i (.*);

  typedef struct packed {
    logic        wr;
    logic [3:0]  dest;
    logic [31:0] data;
    logic        undef;
    logic        unpred;
    logic        trap;
  } respT;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  bit    mValid = 0;
  respT  mResp;
  string mTag = "";
  string curTag = "";
  int    stallCnt = 0;

  function automatic logic [31:0] mk(logic [3:0] top, logic u, logic [1:0] o1,
                                     logic [3:0] vn, logic [3:0] rt, logic n,
                                     logic [1:0] o2, logic [3:0] low);
    return {top, 4'b1110, u, o1, 1'b1, vn, rt, 4'b1011, n, o2, 1'b1, low};
  endfunction

  // behavioural reference written from the requirements
  function automatic respT refModel(logic [31:0] iw, logic cmp, logic cp,
                                    logic en, logic vp);
    respT        r;
    int          size;
    int          idx;
    logic [63:0] rv;
    logic [31:0] lane;
    bit          fixedOk;
    r = '0;
    r.dest = iw[15:12];
    fixedOk = (iw[27:24] == 4'b1110) && iw[20] && (iw[11:8] == 4'b1011) && iw[4]
           && (cmp ? (iw[31:28] == 4'b1110) : (iw[31:28] != 4'b1111));
    size = 0;
    idx  = 0;
    if (iw[22]) begin
      size = 8;  idx = int'({iw[21], iw[6:5]});
    end else if (iw[5]) begin
      size = 16; idx = int'({iw[21], iw[6]});
    end else if (!iw[23] && !iw[6]) begin
      size = 32; idx = int'(iw[21]);
    end
    r.undef = !fixedOk || (size == 0);
    if (r.undef) return r;
    r.unpred = (iw[15:12] == 4'hF) || (iw[3:0] != 4'h0);
    if (!cp) return r;
    r.trap = !en || ((size != 32) && !vp);
    if (r.trap || (iw[15:12] == 4'hF)) return r;
    rv   = regs[{iw[7], iw[19:16]}];
    lane = 32'(rv >> (idx * size));
    if (size == 8)
      lane = iw[23] ? {24'h0, lane[7:0]} : {{24{lane[7]}}, lane[7:0]};
    else if (size == 16)
      lane = iw[23] ? {16'h0, lane[15:0]} : {{16{lane[15]}}, lane[15:0]};
    r.wr   = 1'b1;
    r.data = lane;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: model the edge that just passed, compare, then set rspReady
  task automatic tick(output bit acc);
    @(negedge clk);
    acc = reqValid && (!mValid || rspReady);
    if (mValid && rspReady) mValid = 0;
    if (acc) begin
      mValid = 1;
      mResp  = refModel(instrWord, compactForm, condPass, unitEnable, vecPresent);
      mTag   = curTag;
    end
    chk(rspValid == mValid, "R1", "rspValid", 64'(rspValid), 64'(mValid));
    if (mValid) begin
      chk(rspWrEn == mResp.wr, mTag, "rspWrEn", 64'(rspWrEn), 64'(mResp.wr));
      chk(rspDest == mResp.dest, mTag, "rspDest(R7)", 64'(rspDest), 64'(mResp.dest));
      chk(rspData == mResp.data, mTag, "rspData", 64'(rspData), 64'(mResp.data));
      chk(rspUndef == mResp.undef, mTag, "rspUndef", 64'(rspUndef), 64'(mResp.undef));
      chk(rspUnpred == mResp.unpred, mTag, "rspUnpred", 64'(rspUnpred), 64'(mResp.unpred));
      chk(rspTrap == mResp.trap, mTag, "rspTrap", 64'(rspTrap), 64'(mResp.trap));
    end
    if (stallCnt > 0) begin
      rspReady = 1'b0;
      stallCnt--;
    end else begin
      rspReady = 1'b1;
    end
  endtask

  task automatic send(logic [31:0] iw, logic cp, logic en, logic vp, string tag);
    bit acc;
    instrWord  = iw;
    condPass   = cp;
    unitEnable = en;
    vecPresent = vp;
    reqValid   = 1'b1;
    curTag     = tag;
    #1;
    chk(rfRdAddr == {iw[7], iw[19:16]}, "R7", "rfRdAddr",
        64'(rfRdAddr), 64'({iw[7], iw[19:16]}));
    chk(reqReady == (!mValid || rspReady), "R1", "reqReady",
        64'(reqReady), 64'(!mValid || rspReady));
    do tick(acc); while (!acc);
    reqValid = 1'b0;
  endtask

  task automatic idle(int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      regs[i] = {32'h9F3A71C4 ^ (32'(i) * 32'h01020304),
                 32'h6E85D2B7 + (32'(i) * 32'h11110101)};
    end
    repeat (3) @(negedge clk);
    chk(rspValid == 1'b0, "R1", "reset rspValid", 64'(rspValid), 64'd0);
    chk(reqReady == 1'b1, "R1", "reset reqReady", 64'(reqReady), 64'd1);
    rstN = 1'b1;
    idle(1);

    // R2 R5: every byte lane, both extension modes
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 8; k++)
        send(mk(4'hE, u[0], {1'b1, k[2]}, 4'(k + 3), 4'(k), k[0], k[1:0], 4'h0),
             1, 1, 1, "R2 R5");

    // R3 R5: every halfword lane
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 4; k++)
        send(mk(4'h3, u[0], {1'b0, k[1]}, 4'(k + 9), 4'(k + 4), ~k[0], {k[0], 1'b1}, 4'h0),
             1, 1, 1, "R3 R5");

    // R4: word lanes, legal without the vector extension
    for (int k = 0; k < 2; k++)
      send(mk(4'h0, 1'b0, {1'b0, k[0]}, 4'hC, 4'h2, k[0], 2'b00, 4'h0), 1, 1, 0, "R4");

    // R6: undefined patterns and fixed-bit violations
    send(mk(4'hE, 1'b1, 2'b00, 4'h1, 4'h1, 1'b0, 2'b00, 4'h0), 1, 1, 1, "R6 10x00");
    send(mk(4'hE, 1'b1, 2'b01, 4'h1, 4'h1, 1'b0, 2'b00, 4'h0), 1, 1, 1, "R6 10x00");
    send(mk(4'hE, 1'b0, 2'b00, 4'h1, 4'h1, 1'b0, 2'b10, 4'h0), 1, 1, 1, "R6 x0x10");
    send(mk(4'hE, 1'b1, 2'b01, 4'h1, 4'h1, 1'b0, 2'b10, 4'h0), 0, 0, 0, "R6 x0x10");
    send(mk(4'hE, 1'b0, 2'b10, 4'h1, 4'h1, 1'b0, 2'b00, 4'h0) ^ 32'h0010_0000, 1, 1, 1, "R6 bit20");
    send(mk(4'hE, 1'b0, 2'b10, 4'h1, 4'h1, 1'b0, 2'b00, 4'h0) ^ 32'h0000_0100, 1, 1, 1, "R6 bits11:8");
    send(mk(4'hF, 1'b0, 2'b00, 4'h1, 4'h1, 1'b0, 2'b00, 4'h0), 1, 1, 1, "R6 cond1111");
    compactForm = 1'b1;
    send(mk(4'hE, 1'b0, 2'b01, 4'h5, 4'h6, 1'b1, 2'b00, 4'h0), 1, 1, 1, "R6 compact ok");
    send(mk(4'h0, 1'b0, 2'b01, 4'h5, 4'h6, 1'b1, 2'b00, 4'h0), 1, 1, 1, "R6 compact top");
    compactForm = 1'b0;

    // R8 R12: failed condition
    send(mk(4'h1, 1'b0, 2'b11, 4'h2, 4'h3, 1'b0, 2'b01, 4'h0), 0, 1, 1, "R8 R12");
    send(mk(4'h1, 1'b0, 2'b11, 4'h2, 4'h3, 1'b0, 2'b01, 4'h0), 0, 0, 0, "R8 R12");

    // R9: traps
    send(mk(4'h2, 1'b0, 2'b00, 4'h4, 4'h5, 1'b0, 2'b00, 4'h0), 1, 0, 1, "R9 disabled");
    send(mk(4'h2, 1'b1, 2'b10, 4'h4, 4'h5, 1'b0, 2'b11, 4'h0), 1, 1, 0, "R9 byte novec");
    send(mk(4'h2, 1'b0, 2'b01, 4'h4, 4'h5, 1'b1, 2'b11, 4'h0), 1, 1, 0, "R9 half novec");

    // R10: destinations 15 and 13
    send(mk(4'hE, 1'b0, 2'b10, 4'h7, 4'hF, 1'b1, 2'b10, 4'h0), 1, 1, 1, "R10 dest15");
    send(mk(4'hE, 1'b0, 2'b10, 4'h7, 4'hD, 1'b1, 2'b10, 4'h0), 1, 1, 1, "R10 dest13");

    // R11: nonzero low bits still execute
    send(mk(4'hE, 1'b0, 2'b01, 4'h8, 4'h9, 1'b0, 2'b01, 4'hA), 1, 1, 1, "R11");

    // R1: back-to-back requests against a stalled consumer
    stallCnt = 4;
    send(mk(4'hE, 1'b0, 2'b11, 4'hA, 4'h1, 1'b1, 2'b11, 4'h0), 1, 1, 1, "R1 stall a");
    send(mk(4'hE, 1'b1, 2'b00, 4'hB, 4'h2, 1'b0, 2'b11, 4'h0), 1, 1, 1, "R1 stall b");
    send(mk(4'hE, 1'b0, 2'b00, 4'hC, 4'h3, 1'b1, 2'b00, 4'h0), 1, 1, 1, "R1 stall c");

    idle(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule